// File: doc/BRIEF.md
# Bit-Serial K-Minimum Selector

This block holds a set of unsigned records in a column-organised store, one stored word per bit position that spans every record. When started with a count K, it marks the K records with the smallest values. It walks the bit positions from the most significant to the least significant. Each step takes one cycle and does one masked complement across all records plus one population count, so the run time depends only on the record width and not on the number of records.

Two masks are kept. One is the candidate set that may still hold winners. The other is the committed set, whose records are certainly among the K smallest. The committed set grows, or the candidate set shrinks, until the committed count reaches K. If values tie at the boundary, the scan reaches the last bit without an exact hit. A final cycle then tops up the selection from the tied records, lowest index first, and reports that the result was not exact.

Top module: `kmin_select`

## Requirements
- R1: A load (`ld_en` high) while idle writes `ld_val` into record `ld_idx`, and later queries use that value.
- R2: After reset, `sel`, `done` and `exact` are all zero.
- R3: For 0 < K < N, when the K-th and (K+1)-th smallest values differ, the final `sel` has a 1 in bit i exactly for the K records of smallest value, and `exact` is 1.
- R4: In the case of R3, `done` rises on the clock edge WIDTH-b edges after the edge that took `start`. Here b is the highest bit position where the K-th and (K+1)-th smallest values differ.
- R5: When the K-th and (K+1)-th smallest values are equal, the selection is completed with the lowest-index records of that boundary value, `exact` is 0, and `done` rises WIDTH+1 edges after the start edge.
- R6: With K >= N, every bit of `sel` is set and `done` rises on the start edge itself. `exact` is 1 only when K equals N.
- R7: With K = 0, `sel` is all zeros, `exact` is 1, and `done` rises on the start edge itself.
- R8: A `start` pulse that arrives while a scan is running is ignored.
- R9: A load request that arrives while a scan is running is ignored and leaves the store unchanged.
- R10: `sel`, `done` and `exact` hold their values until the next accepted `start`. Accepting a start that needs a scan clears `done`.
- R11: Whenever `done` is high and K <= N, the number of ones in `sel` equals K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write request for one record |
| ld_idx | input | $clog2(N_REC) | Record index to write |
| ld_val | input | WIDTH | Value to write |
| k_in | input | $clog2(N_REC+1) | Number of minima to select, taken with `start` |
| start | input | 1 | Begin a selection (accepted only while idle) |
| sel | output | N_REC | Bit i set when record i is selected |
| done | output | 1 | Selection finished |
| exact | output | 1 | Selection was decided without a tie fill |

## Verification
The 16-record, 6-bit set with a run of five equal values near the bottom is queried with K = 1 and K = 6. These stop early at different bit depths, and R4 latency is checked every cycle. The same set with K = 4 splits the tied run and forces the fill path. A set of all-distinct values separates early exact stops from full-depth scans. A set of all-equal values shows that ties resolve to the lowest indices. K = 0, K = N and K > N cover the shortcut paths. A run with a mid-scan `start` and a mid-scan load, followed by a repeat query, shows both were dropped.

// File: rtl/kmin_pkg.sv
// Package: shared types for the K-minimum selector.
// Assumes: nothing beyond IEEE 1800-2017.
package kmin_pkg;

    // Controller phases: waiting, bit-serial scan, tie fill
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FILL = 2'd2
    } kmin_state_t;

endpackage

// File: rtl/kmin_colstore.sv
// Module: column store. Record i of the value set lives in bit i of
// WIDTH column words; one column word is read out per cycle.
// Assumes: the writer gates we itself; rd_bit stays below WIDTH.
module kmin_colstore #(
    parameter int N_REC = 16,
    parameter int WIDTH = 6,
    localparam int IDXW = $clog2(N_REC),
    localparam int BITW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [WIDTH-1:0] wr_val,
    input  logic [BITW-1:0]  rd_bit,
    output logic [N_REC-1:0] slice
);

    logic [N_REC-1:0] cols [WIDTH];

    // Scatter one record's bits into every column word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < WIDTH; j++) cols[j] <= '0;
        end else if (we) begin
            for (int j = 0; j < WIDTH; j++) cols[j][wr_idx] <= wr_val[j];
        end
    end

    // Present the addressed bit column across all records
    always_comb slice = cols[rd_bit];

endmodule

// File: rtl/kmin_popcnt.sv
// Module: population count of an N_REC-bit vector.
// Assumes: CNTW can hold N_REC.
module kmin_popcnt #(
    parameter int N_REC = 16,
    localparam int CNTW = $clog2(N_REC + 1)
) (
    input  logic [N_REC-1:0] vec,
    output logic [CNTW-1:0]  total
);

    // Add up the set bits
    always_comb begin
        total = '0;
        for (int i = 0; i < N_REC; i++) total = total + CNTW'(vec[i]);
    end

endmodule

// File: rtl/kmin_fill.sv
// Module: picks the first `need` set bits of `avail`, lowest index first.
// Assumes: need never exceeds the count of ones in avail for a useful
// result; with fewer available, all available bits are picked.
module kmin_fill #(
    parameter int N_REC = 16,
    localparam int CNTW = $clog2(N_REC + 1)
) (
    input  logic [N_REC-1:0] avail,
    input  logic [CNTW-1:0]  need,
    output logic [N_REC-1:0] add
);

    logic [CNTW-1:0] taken;

    // Running prefix count decides each pick
    always_comb begin
        taken = '0;
        add   = '0;
        for (int i = 0; i < N_REC; i++) begin
            if (avail[i] && (taken < need)) begin
                add[i] = 1'b1;
                taken  = taken + CNTW'(1);
            end
        end
    end

endmodule

// File: rtl/kmin_select.sv
// Module: bit-serial K-minimum selector (top).
// Scans stored values MSB to LSB, one bit per cycle, refining a candidate
// mask and a committed mask until K records are committed; ties at the
// boundary are resolved by a lowest-index fill cycle.
// Assumes: N_REC >= 2, WIDTH >= 2; start and loads are ignored while busy.
module kmin_select
    import kmin_pkg::*;
#(
    parameter int N_REC = 16,
    parameter int WIDTH = 6,
    localparam int IDXW = $clog2(N_REC),
    localparam int CNTW = $clog2(N_REC + 1),
    localparam int BITW = $clog2(WIDTH),
    localparam int LATW = $clog2(WIDTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDXW-1:0]  ld_idx,
    input  logic [WIDTH-1:0] ld_val,
    input  logic [CNTW-1:0]  k_in,
    input  logic             start,
    output logic [N_REC-1:0] sel,
    output logic             done,
    output logic             exact
);

    localparam logic [CNTW-1:0] N_CNT   = CNTW'(N_REC);
    localparam logic [BITW-1:0] TOP_BIT = BITW'(WIDTH - 1);

    kmin_state_t      state;
    logic [N_REC-1:0] m_q, v_q;
    logic [CNTW-1:0]  k_q;
    logic [BITW-1:0]  bit_q;
    logic             done_q, exact_q;
    logic [LATW-1:0]  lat_cnt;

    logic [N_REC-1:0] slice, n_vec, cand, fill_add;
    logic [CNTW-1:0]  cnt, v_cnt, need;
    logic             store_we;

    // Loads reach the store only while idle
    assign store_we = ld_en && (state == ST_IDLE);

    kmin_colstore #(.N_REC(N_REC), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(store_we), .wr_idx(ld_idx),
        .wr_val(ld_val), .rd_bit(bit_q), .slice(slice)
    );

    // Records with a 0 at this bit that are still candidates
    always_comb begin
        n_vec = m_q & ~slice;
        cand  = n_vec | v_q;
        need  = k_q - v_cnt;
    end

    kmin_popcnt #(.N_REC(N_REC)) u_cnt_cand (.vec(cand), .total(cnt));
    kmin_popcnt #(.N_REC(N_REC)) u_cnt_sel  (.vec(v_q),  .total(v_cnt));

    kmin_fill #(.N_REC(N_REC)) u_fill (
        .avail(m_q & ~v_q), .need(need), .add(fill_add)
    );

    // Controller: start handling, per-bit mask refinement, tie fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            m_q     <= '0;
            v_q     <= '0;
            k_q     <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
            exact_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        k_q <= k_in;
                        if (k_in == '0) begin
                            v_q     <= '0;
                            done_q  <= 1'b1;
                            exact_q <= 1'b1;
                        end else if (k_in >= N_CNT) begin
                            v_q     <= '1;
                            done_q  <= 1'b1;
                            exact_q <= (k_in == N_CNT);
                        end else begin
                            m_q     <= '1;
                            v_q     <= '0;
                            bit_q   <= TOP_BIT;
                            done_q  <= 1'b0;
                            exact_q <= 1'b0;
                            state   <= ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    if (cnt == k_q) begin
                        v_q     <= cand;
                        done_q  <= 1'b1;
                        exact_q <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        if (cnt > k_q) m_q <= n_vec;
                        else           v_q <= cand;
                        if (bit_q == '0) state <= ST_FILL;
                        else             bit_q <= bit_q - BITW'(1);
                    end
                end
                ST_FILL: begin
                    v_q     <= v_q | fill_add;
                    done_q  <= 1'b1;
                    exact_q <= 1'b0;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Cycles spent busy, kept for the latency assertion
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) lat_cnt <= '0;
        else                            lat_cnt <= lat_cnt + LATW'(1);
    end

    assign sel   = v_q;
    assign done  = done_q;
    assign exact = exact_q;

    // R11: finished selection holds exactly K ones when K fits
    assert_sel_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && k_q <= N_CNT) |-> ($countones(v_q) == k_q));

    // R4/R5: a scan never outlasts WIDTH steps plus the fill cycle
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (lat_cnt <= LATW'(WIDTH)));

    // R3: while scanning, fewer than K records are committed
    assert_v_below_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ($countones(v_q) < k_q));

    // R8: a start seen mid-scan does not replace K
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(k_q));

    // R6: oversized K selects everything on the next edge
    assert_all_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && k_in >= N_CNT) |=> (done_q && (&v_q)));

endmodule

// File: tb/kmin_select_test.sv
// Bench: behavioural ranking model; compares done/sel/exact every cycle.
module kmin_select_test;

    localparam int N_REC = 16;
    localparam int WIDTH = 6;
    localparam int IDXW  = $clog2(N_REC);
    localparam int CNTW  = $clog2(N_REC + 1);

    logic             clk = 1'b0;
    logic             rst_n, ld_en, start;
    logic [IDXW-1:0]  ld_idx;
    logic [WIDTH-1:0] ld_val;
    logic [CNTW-1:0]  k_in;
    logic [N_REC-1:0] sel;
    logic             done, exact;

    int checks = 0;
    int fails  = 0;
    int vals [N_REC];

    always #4 clk = ~clk;

    kmin_select #(.N_REC(N_REC), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_val(ld_val), .k_in(k_in), .start(start),
        .sel(sel), .done(done), .exact(exact)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < N_REC; i++) begin
            @(negedge clk);
            ld_en  = 1'b1;
            ld_idx = IDXW'(i);
            ld_val = WIDTH'(vals[i]);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Rank by (value, index), predict result and latency, check each cycle
    task automatic run_query(int k, bit inject, string req);
        int ord [N_REC];
        bit used [N_REC];
        logic [N_REC-1:0] exp_sel;
        bit exp_exact;
        int lat;
        for (int i = 0; i < N_REC; i++) used[i] = 1'b0;
        for (int r = 0; r < N_REC; r++) begin
            int best = -1;
            for (int i = 0; i < N_REC; i++)
                if (!used[i] && (best < 0 || vals[i] < vals[best])) best = i;
            ord[r] = best;
            used[best] = 1'b1;
        end
        exp_sel = '0;
        if (k == 0) begin
            exp_exact = 1'b1; lat = 0;
        end else if (k >= N_REC) begin
            exp_sel = '1; exp_exact = (k == N_REC); lat = 0;
        end else begin
            int a, b;
            for (int r = 0; r < k; r++) exp_sel[ord[r]] = 1'b1;
            a = vals[ord[k-1]];
            b = vals[ord[k]];
            if (a != b) begin
                int hb = 0;
                for (int j = 0; j < WIDTH; j++) if (((a ^ b) >> j) & 1) hb = j;
                lat = WIDTH - hb; exp_exact = 1'b1;
            end else begin
                lat = WIDTH + 1; exp_exact = 1'b0;
            end
        end
        @(negedge clk);
        k_in  = CNTW'(k);
        start = 1'b1;
        @(posedge clk);
        for (int t = 0; t <= lat + 3; t++) begin
            @(negedge clk);
            if (t == 0) start = 1'b0;
            check(req, 64'(done), 64'(t >= lat), $sformatf("done at cycle %0d", t));
            if (t >= lat) begin
                check(req, 64'(sel), 64'(exp_sel), $sformatf("sel at cycle %0d", t));
                check(req, 64'(exact), 64'(exp_exact), $sformatf("exact at cycle %0d", t));
            end
            if (inject && t == 1) begin
                start  = 1'b1;
                k_in   = CNTW'(1);
                ld_en  = 1'b1;
                ld_idx = '0;
                ld_val = '0;
            end
            if (inject && t == 2) begin
                start = 1'b0;
                ld_en = 1'b0;
            end
        end
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_en = 1'b0; start = 1'b0;
        ld_idx = '0; ld_val = '0; k_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2", 64'(sel), 64'd0, "sel after reset");
        check("R2", 64'(done), 64'd0, "done after reset");
        check("R2", 64'(exact), 64'd0, "exact after reset");

        // R1: set with a run of equal minima
        vals = '{53, 20, 5, 7, 1, 59, 5, 22, 12, 28, 60, 45, 5, 61, 5, 5};
        load_all();
        run_query(1, 1'b0, "R3 R4 R1");
        run_query(6, 1'b0, "R3 R4");
        run_query(4, 1'b0, "R5 R10");
        run_query(0, 1'b0, "R7");
        run_query(16, 1'b0, "R6");
        run_query(20, 1'b0, "R6");
        // R8 R9: mid-scan start and load are dropped
        run_query(4, 1'b1, "R8 R9");
        run_query(4, 1'b0, "R9");

        // All distinct values
        for (int i = 0; i < N_REC; i++) vals[i] = (i * 37 + 11) % 64;
        load_all();
        run_query(8, 1'b0, "R3 R4");
        run_query(15, 1'b0, "R3 R11");

        // All equal values: lowest indices win
        for (int i = 0; i < N_REC; i++) vals[i] = 42;
        load_all();
        run_query(3, 1'b0, "R5");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule